// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block chooses the low-power state the system enters when the processor issues a wait-for-interrupt or wait-for-event. It also steps the system back out of that state. The choice depends on three configuration bits sampled at the request: a deep-sleep flag, a power-down select and a low-power regulator select.

There are three low-power states:
- Sleep gates only the processor clock.
- Stop gates every core-domain clock.
- Standby switches the core domain off.

Entry to a deep state waits while a flash program operation or a peripheral-bus access is still running. The entry is dropped if any interrupt, line or alarm flag is pending.

How the block leaves a state depends on how it entered:
- A state entered by wait-for-interrupt ends on an acknowledged interrupt.
- A state entered by wait-for-event ends on an event.
- Standby ends only on reset-class sources, and it leaves through a one-cycle wakeup reset.

When the regulator was in low-power mode during Stop, a settling window of fixed length is inserted before the core clocks return. Every exit from Stop forces the system clock onto the internal RC oscillator. An automatic entry is also made when the lowest-priority handler returns, if sleep-on-exit is enabled.

Top module: `lpm_seq`

## Requirements
- R1: After reset, `state_o` is 0 (Run), and every gate, power, regulator, clock-select and wakeup-reset output is 0. State codes: 0 Run, 1 Sleep, 2 Entry-hold, 3 Stop, 4 Regulator-ramp, 5 Standby, 6 Wakeup-reset.
- R2: In Run, a request (`wait_req`) with `deep_i`=0 gives Sleep (1) on the next cycle. In Sleep, `cpu_clk_off` is 1 and `core_clk_off` is 0.
- R3: Sleep or Stop entered with `wait_is_evt`=0 ends only on `irq_ack`. If entered with `wait_is_evt`=1, it ends only on `evt_in`. The other input has no effect on the state.
- R4: When `sleep_on_exit` is 1, a pulse on `isr_last_ret` in Run counts as a wait-for-interrupt request. When `sleep_on_exit` is 0, the pulse has no effect.
- R5: A request with `deep_i`=1 and `pwrdn_i`=0 gives Stop (3), with `core_clk_off`=1. In Stop, `reg_lp` equals the `lpreg_i` value sampled at the request.
- R6: A deep request made while `pend_any` is 1 is ignored. The state stays Run (0).
- R7: A deep request made while `flash_busy` or `bus_busy` is 1 goes to Entry-hold (2), with the core clocks still running. The state moves on to its target once both busy flags are 0. It returns to Run if `pend_any` rises during the hold.
- R8: Leaving Stop with the sampled low-power bit at 0 returns to Run on the next cycle. `hsi_force` is 1 for exactly the first Run cycle after any Stop exit.
- R9: Leaving Stop with the sampled low-power bit at 1 spends exactly `WAKE_DLY` cycles in Regulator-ramp (4), with the core clocks off and `reg_lp` at 0, before Run.
- R10: A deep request with `pwrdn_i`=1 gives Standby (5), with `core_pwr_off`=1. Standby ends on any of four sources: a rising edge of a wakeup pin whose enable bit is 1, a rising edge of `alarm_in`, `ext_rst`, or `wdg_rst`. A rising edge on a disabled pin has no effect.
- R11: A Standby exit passes through Wakeup-reset (6) for one cycle, with `wake_rst`=1, then goes to Run.
- R12: A request arriving while the state is not Run is ignored. The state changes by at most one step per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wait_req | input | 1 | wait instruction executed (one-cycle pulse) |
| wait_is_evt | input | 1 | 1 = wait-for-event, 0 = wait-for-interrupt |
| isr_last_ret | input | 1 | return from the lowest-priority handler |
| sleep_on_exit | input | 1 | enable automatic entry on handler return |
| deep_i | input | 1 | deep-sleep flag |
| pwrdn_i | input | 1 | deep state is Standby (1) or Stop (0) |
| lpreg_i | input | 1 | regulator low-power in Stop |
| pend_any | input | 1 | any line, interrupt or alarm flag pending |
| flash_busy | input | 1 | flash program operation in progress |
| bus_busy | input | 1 | peripheral-bus access in progress |
| irq_ack | input | 1 | interrupt acknowledged |
| evt_in | input | 1 | wakeup event |
| wk_pin | input | NWK | wakeup pins |
| wk_en | input | NWK | wakeup pin enables |
| alarm_in | input | 1 | alarm level |
| ext_rst | input | 1 | external reset request |
| wdg_rst | input | 1 | watchdog reset request |
| state_o | output | 3 | current state code |
| cpu_clk_off | output | 1 | processor clock gated |
| core_clk_off | output | 1 | all core-domain clocks gated |
| reg_lp | output | 1 | regulator in low-power mode |
| core_pwr_off | output | 1 | core domain powered off |
| hsi_force | output | 1 | select internal RC as system clock |
| wake_rst | output | 1 | wakeup reset pulse |

## Verification
The hardest case to reach from the ports is Entry-hold. It needs a deep request that arrives while a busy flag is high, and the flags then have to fall in stages. The bench raises the flash flag with the request, swaps it for the bus flag for a cycle, and checks that the hold persists. Only after both flags are low does it check that the state goes to Stop. A second run raises `pend_any` mid-hold to check the abort path. The regulator ramp is counted cycle by cycle, and a disabled wakeup pin is toggled while in Standby to check that it is ignored.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_HOLD  = 3'd2,
    ST_STOP  = 3'd3,
    ST_RAMP  = 3'd4,
    ST_STBY  = 3'd5,
    ST_WRST  = 3'd6
  } lpm_state_e;

  typedef enum logic [1:0] {
    TG_SLEEP = 2'd0,
    TG_STOP  = 2'd1,
    TG_STBY  = 2'd2
  } lpm_tgt_e;
endpackage

// File: rtl/lpm_entry.sv
module lpm_entry
  import lpm_pkg::*;
(
  input  logic     wait_req,
  input  logic     wait_is_evt,
  input  logic     isr_last_ret,
  input  logic     sleep_on_exit,
  input  logic     deep_i,
  input  logic     pwrdn_i,
  output logic     req,
  output logic     req_evt,
  output lpm_tgt_e tgt
);
  logic auto_req;

  always_comb begin
    auto_req = sleep_on_exit && isr_last_ret;
    req      = wait_req || auto_req;
    // an automatic entry behaves as wait-for-interrupt
    req_evt  = wait_req && wait_is_evt;
    if (!deep_i)      tgt = TG_SLEEP;
    else if (pwrdn_i) tgt = TG_STBY;
    else              tgt = TG_STOP;
  end
endmodule

// File: rtl/lpm_ramp.sv
module lpm_ramp #(
  parameter int WAKE_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = (WAKE_DLY < 2) ? 1 : $clog2(WAKE_DLY);
  localparam logic [CW-1:0] LOAD_V = CW'(WAKE_DLY - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                  cnt_d = LOAD_V;
    else if (run && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/lpm_edge.sv
module lpm_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en,
  output logic         hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign hit = |(lvl & ~prev_q & en);
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int NWK      = 3,
  parameter int WAKE_DLY = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wait_req,
  input  logic           wait_is_evt,
  input  logic           isr_last_ret,
  input  logic           sleep_on_exit,
  input  logic           deep_i,
  input  logic           pwrdn_i,
  input  logic           lpreg_i,
  input  logic           pend_any,
  input  logic           flash_busy,
  input  logic           bus_busy,
  input  logic           irq_ack,
  input  logic           evt_in,
  input  logic [NWK-1:0] wk_pin,
  input  logic [NWK-1:0] wk_en,
  input  logic           alarm_in,
  input  logic           ext_rst,
  input  logic           wdg_rst,
  output logic [2:0]     state_o,
  output logic           cpu_clk_off,
  output logic           core_clk_off,
  output logic           reg_lp,
  output logic           core_pwr_off,
  output logic           hsi_force,
  output logic           wake_rst
);
  localparam int EW = NWK + 1;

  lpm_state_e state_q, state_d;
  logic       evt_q, evt_d, stby_q, stby_d, lp_q, lp_d, hsi_d;
  logic       req, req_evt, busy, wake_cpu, edge_hit, stby_wake;
  logic       ramp_load, ramp_done;
  lpm_tgt_e   tgt;

  lpm_entry u_entry (
    .wait_req(wait_req), .wait_is_evt(wait_is_evt),
    .isr_last_ret(isr_last_ret), .sleep_on_exit(sleep_on_exit),
    .deep_i(deep_i), .pwrdn_i(pwrdn_i),
    .req(req), .req_evt(req_evt), .tgt(tgt)
  );

  lpm_ramp #(.WAKE_DLY(WAKE_DLY)) u_ramp (
    .clk(clk), .rst_n(rst_n), .load(ramp_load),
    .run(state_q == ST_RAMP), .done(ramp_done)
  );

  lpm_edge #(.W(EW)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({alarm_in, wk_pin}), .en({1'b1, wk_en}), .hit(edge_hit)
  );

  assign busy      = flash_busy || bus_busy;
  assign wake_cpu  = evt_q ? evt_in : irq_ack;
  assign stby_wake = edge_hit || ext_rst || wdg_rst;
  assign ramp_load = (state_q == ST_STOP) && wake_cpu && lp_q;

  always_comb begin
    state_d = state_q;
    evt_d   = evt_q;
    stby_d  = stby_q;
    lp_d    = lp_q;
    unique case (state_q)
      ST_RUN: if (req) begin
        evt_d  = req_evt;
        lp_d   = lpreg_i;
        stby_d = (tgt == TG_STBY);
        if (tgt == TG_SLEEP)  state_d = ST_SLEEP;
        else if (!pend_any) begin
          if (busy)                state_d = ST_HOLD;
          else if (tgt == TG_STBY) state_d = ST_STBY;
          else                     state_d = ST_STOP;
        end
      end
      ST_HOLD: begin
        if (pend_any)   state_d = ST_RUN;
        else if (!busy) state_d = stby_q ? ST_STBY : ST_STOP;
      end
      ST_SLEEP: if (wake_cpu) state_d = ST_RUN;
      ST_STOP:  if (wake_cpu) state_d = lp_q ? ST_RAMP : ST_RUN;
      ST_RAMP:  if (ramp_done) state_d = ST_RUN;
      ST_STBY:  if (stby_wake) state_d = ST_WRST;
      ST_WRST:  state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
    hsi_d = (state_d == ST_RUN) &&
            ((state_q == ST_STOP) || (state_q == ST_RAMP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      evt_q     <= 1'b0;
      stby_q    <= 1'b0;
      lp_q      <= 1'b0;
      hsi_force <= 1'b0;
    end else begin
      state_q   <= state_d;
      evt_q     <= evt_d;
      stby_q    <= stby_d;
      lp_q      <= lp_d;
      hsi_force <= hsi_d;
    end
  end

  assign state_o      = state_q;
  assign cpu_clk_off  = (state_q != ST_RUN);
  assign core_clk_off = (state_q == ST_STOP) || (state_q == ST_RAMP) ||
                        (state_q == ST_STBY) || (state_q == ST_WRST);
  assign reg_lp       = (state_q == ST_STOP) && lp_q;
  assign core_pwr_off = (state_q == ST_STBY);
  assign wake_rst     = (state_q == ST_WRST);

  // R6
  pend_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && wait_req && deep_i && pend_any) |=> state_q == ST_RUN);

  // R7
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && busy && !pend_any) |=> state_q == ST_HOLD);

  // R9
  ramp_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RAMP && !ramp_done) |=> state_q == ST_RAMP);

  // R11
  wrst_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_WRST |=> state_q == ST_RUN);

  // R10
  stby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STBY && !stby_wake) |=> state_q == ST_STBY);

  // R12
  sleep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_SLEEP |=> (state_q == ST_SLEEP || state_q == ST_RUN));
endmodule

// File: tb/test_lpm_seq.sv
module test_lpm_seq;
  localparam int NWK = 3;
  localparam int DLY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_req = 0, wait_is_evt = 0, isr_last_ret = 0, sleep_on_exit = 0;
  logic deep_i = 0, pwrdn_i = 0, lpreg_i = 0, pend_any = 0;
  logic flash_busy = 0, bus_busy = 0, irq_ack = 0, evt_in = 0;
  logic [NWK-1:0] wk_pin = '0, wk_en = '0;
  logic alarm_in = 0, ext_rst = 0, wdg_rst = 0;
  logic [2:0] state_o;
  logic cpu_clk_off, core_clk_off, reg_lp, core_pwr_off, hsi_force, wake_rst;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  lpm_seq #(.NWK(NWK), .WAKE_DLY(DLY)) i_lpm_seq (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .wait_is_evt(wait_is_evt),
    .isr_last_ret(isr_last_ret), .sleep_on_exit(sleep_on_exit),
    .deep_i(deep_i), .pwrdn_i(pwrdn_i), .lpreg_i(lpreg_i), .pend_any(pend_any),
    .flash_busy(flash_busy), .bus_busy(bus_busy), .irq_ack(irq_ack),
    .evt_in(evt_in), .wk_pin(wk_pin), .wk_en(wk_en), .alarm_in(alarm_in),
    .ext_rst(ext_rst), .wdg_rst(wdg_rst), .state_o(state_o),
    .cpu_clk_off(cpu_clk_off), .core_clk_off(core_clk_off), .reg_lp(reg_lp),
    .core_pwr_off(core_pwr_off), .hsi_force(hsi_force), .wake_rst(wake_rst)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic request(input logic evt);
    wait_req = 1'b1; wait_is_evt = evt;
    step();
    wait_req = 1'b0; wait_is_evt = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", state_o, 0);
    chk("R1 outputs", {cpu_clk_off, core_clk_off, reg_lp, core_pwr_off,
                       hsi_force, wake_rst}, 0);
  endtask

  task automatic t_sleep_wfi();
    deep_i = 0;
    request(1'b0);
    chk("R2 sleep state", state_o, 1);
    chk("R2 cpu gate", cpu_clk_off, 1);
    chk("R2 core gate", core_clk_off, 0);
    evt_in = 1; step(); evt_in = 0;
    chk("R3 event ignored after wfi", state_o, 1);
    wait_req = 1; deep_i = 1; step(); wait_req = 0; deep_i = 0;
    chk("R12 request ignored in sleep", state_o, 1);
    irq_ack = 1; step(); irq_ack = 0;
    chk("R3 wfi irq exit", state_o, 0);
  endtask

  task automatic t_sleep_wfe();
    request(1'b1);
    chk("R3 wfe sleep", state_o, 1);
    irq_ack = 1; step(); irq_ack = 0;
    chk("R3 irq ignored after wfe", state_o, 1);
    evt_in = 1; step(); evt_in = 0;
    chk("R3 wfe event exit", state_o, 0);
  endtask

  task automatic t_sleep_on_exit();
    sleep_on_exit = 0; isr_last_ret = 1; step(); isr_last_ret = 0;
    chk("R4 disabled no entry", state_o, 0);
    sleep_on_exit = 1; isr_last_ret = 1; step(); isr_last_ret = 0;
    chk("R4 auto entry", state_o, 1);
    evt_in = 1; step(); evt_in = 0;
    chk("R4 auto entry is wfi", state_o, 1);
    irq_ack = 1; step(); irq_ack = 0; sleep_on_exit = 0;
    chk("R4 exit", state_o, 0);
  endtask

  task automatic t_stop_normal();
    deep_i = 1; pwrdn_i = 0; lpreg_i = 0;
    request(1'b0);
    chk("R5 stop state", state_o, 3);
    chk("R5 core gate", core_clk_off, 1);
    chk("R5 regulator normal", reg_lp, 0);
    irq_ack = 1; step(); irq_ack = 0;
    chk("R8 direct run", state_o, 0);
    chk("R8 hsi pulse", hsi_force, 1);
    step();
    chk("R8 hsi one cycle", hsi_force, 0);
  endtask

  task automatic t_stop_abort();
    pend_any = 1; request(1'b0); pend_any = 0;
    chk("R6 pending aborts", state_o, 0);
    chk("R6 no gate", cpu_clk_off, 0);
  endtask

  task automatic t_stop_hold();
    flash_busy = 1; request(1'b0);
    chk("R7 hold state", state_o, 2);
    chk("R7 core clocks on in hold", core_clk_off, 0);
    flash_busy = 0; bus_busy = 1; step();
    chk("R7 hold on bus busy", state_o, 2);
    bus_busy = 0; step();
    chk("R7 enter after idle", state_o, 3);
    irq_ack = 1; step(); irq_ack = 0;
    chk("R7 back to run", state_o, 0);
    flash_busy = 1; request(1'b0);
    chk("R7 hold again", state_o, 2);
    pend_any = 1; step(); pend_any = 0; flash_busy = 0;
    chk("R7 pending aborts hold", state_o, 0);
  endtask

  task automatic t_stop_lp();
    lpreg_i = 1;
    request(1'b1); lpreg_i = 0;
    chk("R5 regulator low power", reg_lp, 1);
    evt_in = 1; step(); evt_in = 0;
    chk("R9 ramp entered", state_o, 4);
    chk("R9 regulator normal in ramp", reg_lp, 0);
    chk("R9 core gated in ramp", core_clk_off, 1);
    for (int k = 1; k < DLY; k++) begin
      step();
      chk("R9 ramp held", state_o, 4);
    end
    step();
    chk("R9 run after ramp", state_o, 0);
    chk("R8 hsi after ramp", hsi_force, 1);
  endtask

  task automatic enter_stby();
    deep_i = 1; pwrdn_i = 1;
    request(1'b0);
    chk("R10 standby state", state_o, 5);
    chk("R10 power off", core_pwr_off, 1);
  endtask

  task automatic leave_stby(input string tag);
    chk(tag, state_o, 6);
    chk("R11 wake reset", wake_rst, 1);
    step();
    chk("R11 run after reset", state_o, 0);
    chk("R11 reset one cycle", wake_rst, 0);
  endtask

  task automatic t_standby();
    wk_en = 3'b010;
    enter_stby();
    wk_pin = 3'b001; step();
    chk("R10 disabled pin ignored", state_o, 5);
    wk_pin = 3'b011; step();
    leave_stby("R10 pin wake");
    wk_pin = '0; step();
    enter_stby();
    alarm_in = 1; step();
    leave_stby("R10 alarm wake");
    alarm_in = 0;
    enter_stby();
    wdg_rst = 1; step(); wdg_rst = 0;
    leave_stby("R10 watchdog wake");
    enter_stby();
    ext_rst = 1; step(); ext_rst = 0;
    leave_stby("R10 external wake");
    deep_i = 0; pwrdn_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_sleep_wfi();
    t_sleep_wfe();
    t_sleep_on_exit();
    t_stop_normal();
    t_stop_abort();
    t_stop_hold();
    t_stop_lp();
    t_standby();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule